// File: doc/BRIEF.md
# Serial Converter Result Reader

This block is the host-side reader for a low-rate, read-only serial converter. The converter has one combined output line that carries both a "result ready" indication and the serial data. The reader watches that line, and when it falls low the reader issues a burst of serial clock pulses. It shifts in the returned word and checks the fixed fields of the word. It then presents the conversion code together with an out-of-range flag and a transfer-integrity flag on a valid/ready handshake.

The reader also owns the converter's active-low power-down/restart output. On a restart request it holds that output low for a programmable number of cycles. A restart also discards any frame in progress and any result not yet taken. After a restart or after a finished read, the reader waits until the line has been seen high before it accepts another falling edge as a new result.

The clock low time, the clock high time, the sampling delay after each falling edge and the restart pulse length are parameters counted in system clock cycles. A second parameter chooses between two delivery modes: a result is either held until the consumer accepts it (default) or shown for a single cycle.

Top module: `sdadc_host_reader`

## Requirements
- R1: While `rst_n` is low, `ser_clk` is high, `res_valid` is low and `conv_pwr_n` is low. After `rst_n` is released, `conv_pwr_n` rises on the RST_CYC-th rising clock edge.
- R2: A one-cycle `conv_restart` pulse drives `conv_pwr_n` low from the next cycle for exactly RST_CYC cycles. `ser_clk` stays high while `conv_pwr_n` is low. A frame in progress is abandoned and produces no result, and a result not yet taken is withdrawn (`res_valid` low).
- R3: After `conv_pwr_n` rises, or after a completed frame, no clock pulse is issued until the synchronized `ser_dat` has been seen high and then low. A line that stays low issues no pulse.
- R4: A frame is exactly 24 falling edges on `ser_clk`. Each low phase lasts LOW_CYC cycles and each high phase between pulses lasts HIGH_CYC cycles. `ser_clk` idles high.
- R5: `ser_dat` passes through a SYNC_STAGES-flop synchronizer and is sampled once per low phase, SAMPLE_DLY cycles into it, most significant bit first. Frame bits 23..12 (the first 12 received) form `res_code`. `res_valid` rises HIGH_CYC cycles after the last rising edge of `ser_clk`.
- R6: `res_err` is a copy of frame bit 5, the third status bit received.
- R7: `res_bad` is 1 exactly when any of these holds: frame bits 2..0 differ from 101, bits 11..8 are not all zero, bit 6 is not zero, or bits 4..3 are not 00. Bit 7, the ready status bit, is not checked.
- R8: With HOLD_RESULT=1, `res_valid` and the result fields stay unchanged while `res_ready` is low. `res_valid` falls in the cycle after a cycle with both `res_valid` and `res_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the caller |
| conv_restart | input | 1 | One-cycle request to power-cycle and restart the converter |
| conv_pwr_n | output | 1 | Active-low power-down/restart to the converter |
| ser_clk | output | 1 | Serial clock to the converter, idle high |
| ser_dat | input | 1 | Combined ready/data line from the converter |
| res_ready | input | 1 | Consumer accepts the presented result |
| res_valid | output | 1 | A result is presented |
| res_code | output | CODE_BITS | Conversion code (offset binary) |
| res_err | output | 1 | Converter reported an out-of-range input |
| res_bad | output | 1 | Fixed fields of the frame did not match |

## Verification
`conv_pwr_n` is due low in the first cycle after the restart request and high again RST_CYC cycles later. The bench counts these cycles from the request. Clock widths are measured phase by phase, and the bench checks that each frame has 24 falling edges. The result is due HIGH_CYC cycles after the last clock rise. The bench counts cycles from that rise to `res_valid` and compares the fields there. `res_valid` is due low one cycle after an accepting handshake, and the bench samples it there. All sampling happens 2 ns after the rising clock edge.

// File: rtl/sdadc_pkg.sv
package sdadc_pkg;

  localparam int CODE_BITS  = 12;
  localparam int FILL_BITS  = 4;
  localparam int STAT_BITS  = 8;
  localparam int FRAME_BITS = CODE_BITS + FILL_BITS + STAT_BITS;

  // fixed status fields, positions counted from the last bit received
  localparam logic [2:0] PAT_EXPECT = 3'b101;
  localparam logic [1:0] ID_EXPECT  = 2'b00;

  typedef logic [FRAME_BITS-1:0] frame_t;

  typedef struct packed {
    logic [CODE_BITS-1:0] code;
    logic                 err;
    logic                 bad;
  } result_t;

  typedef enum logic [1:0] {
    ST_RESET     = 2'd0,
    ST_WAIT_HIGH = 2'd1,
    ST_WAIT_LOW  = 2'd2,
    ST_SHIFT     = 2'd3
  } rd_state_e;

  function automatic result_t decode_frame(input frame_t w);
    result_t r;
    r.code = w[FRAME_BITS-1 -: CODE_BITS];
    r.err  = w[5];
    r.bad  = (w[2:0] != PAT_EXPECT) ||
             (w[STAT_BITS +: FILL_BITS] != '0) ||
             w[6] ||
             (w[4:3] != ID_EXPECT);
    return r;
  endfunction

endpackage

// File: rtl/sdadc_line_sync.sv
module sdadc_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] stage_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else        stage_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/sdadc_restart_pulse.sv
module sdadc_restart_pulse #(
  parameter int RST_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pwr_n
);

  localparam int CW = $clog2(RST_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pwr_q, pwr_d;

  always_comb begin
    cnt_d = cnt_q;
    pwr_d = pwr_q;
    if (req) begin
      cnt_d = CW'(RST_CYC);
      pwr_d = 1'b0;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
      pwr_d = (cnt_q == CW'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(RST_CYC);
      pwr_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pwr_q <= pwr_d;
    end
  end

  assign pwr_n = pwr_q;

  assert_req_drives_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !pwr_q);

  assert_release_ends_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_q) |-> (cnt_q == '0));

endmodule

// File: rtl/sdadc_sclk_gen.sv
module sdadc_sclk_gen #(
  parameter int FRAME_BITS = 24,
  parameter int LOW_CYC    = 16,
  parameter int HIGH_CYC   = 13,
  parameter int SAMPLE_DLY = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  output logic sclk,
  output logic sample_stb,
  output logic frame_done,
  output logic busy
);

  localparam int MAX_PH = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW     = $clog2(MAX_PH + 1);
  localparam int BW     = $clog2(FRAME_BITS);

  logic [CW-1:0] ph_q, ph_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          sclk_q, sclk_d;
  logic          busy_q, busy_d;
  logic          done_d;

  always_comb begin
    ph_d   = ph_q;
    bit_d  = bit_q;
    sclk_d = sclk_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (abort) begin
      ph_d   = '0;
      bit_d  = '0;
      sclk_d = 1'b1;
      busy_d = 1'b0;
    end else if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sclk_d = 1'b0;
        ph_d   = '0;
        bit_d  = '0;
      end
    end else if (!sclk_q) begin
      if (ph_q == CW'(LOW_CYC - 1)) begin
        sclk_d = 1'b1;
        ph_d   = '0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end else begin
      if (ph_q == CW'(HIGH_CYC - 1)) begin
        ph_d = '0;
        if (bit_q == BW'(FRAME_BITS - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          bit_d  = bit_q + 1'b1;
        end
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      bit_q  <= '0;
      sclk_q <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      bit_q  <= bit_d;
      sclk_q <= sclk_d;
      busy_q <= busy_d;
    end
  end

  assign sclk       = sclk_q;
  assign busy       = busy_q;
  assign frame_done = done_d;
  assign sample_stb = busy_q & ~sclk_q & ~abort & (ph_q == CW'(SAMPLE_DLY));

  assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> sclk_q);

  assert_bit_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q < BW'(FRAME_BITS)));

  assert_phase_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (ph_q < CW'(MAX_PH)));

  assert_sample_in_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sclk_q);

endmodule

// File: rtl/sdadc_frame_check.sv
module sdadc_frame_check
  import sdadc_pkg::*;
#(
  parameter bit HOLD_RESULT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 sample_stb,
  input  logic                 bit_in,
  input  logic                 frame_done,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [CODE_BITS-1:0] res_code,
  output logic                 res_err,
  output logic                 res_bad
);

  frame_t  shift_q, shift_d;
  result_t res_q, res_d;
  logic    vld_q, vld_d;
  logic    take;

  generate
    if (HOLD_RESULT) begin : g_hold
      assign take = res_ready;
    end else begin : g_pulse
      assign take = 1'b1;
    end
  endgenerate

  always_comb begin
    shift_d = shift_q;
    if (flush)           shift_d = '0;
    else if (sample_stb) shift_d = {shift_q[FRAME_BITS-2:0], bit_in};
  end

  always_comb begin
    res_d = res_q;
    vld_d = vld_q;
    if (flush) begin
      vld_d = 1'b0;
    end else if (frame_done) begin
      res_d = decode_frame(shift_q);
      vld_d = 1'b1;
    end else if (vld_q && take) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      shift_q <= shift_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
    end
  end

  assign res_valid = vld_q;
  assign res_code  = res_q.code;
  assign res_err   = res_q.err;
  assign res_bad   = res_q.bad;

  generate
    if (HOLD_RESULT) begin : g_hold_chk
      assert_hold_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !res_ready && !flush) |=> vld_q);

      assert_hold_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !res_ready && !flush && !frame_done) |=> $stable(res_q));
    end
  endgenerate

  assert_flush_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vld_q);

endmodule

// File: rtl/sdadc_host_reader.sv
module sdadc_host_reader
  import sdadc_pkg::*;
#(
  parameter int LOW_CYC     = 16,
  parameter int HIGH_CYC    = 13,
  parameter int SAMPLE_DLY  = 12,
  parameter int RST_CYC     = 13,
  parameter int SYNC_STAGES = 2,
  parameter bit HOLD_RESULT = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_restart,
  output logic                 conv_pwr_n,
  output logic                 ser_clk,
  input  logic                 ser_dat,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [CODE_BITS-1:0] res_code,
  output logic                 res_err,
  output logic                 res_bad
);

  rd_state_e state_q, state_d;
  logic      line_s;
  logic      pwr_n;
  logic      start;
  logic      sample_stb;
  logic      frame_done;
  logic      shifting;
  logic      abort;

  sdadc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ser_dat),
    .dout (line_s)
  );

  sdadc_restart_pulse #(.RST_CYC(RST_CYC)) u_rst (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (conv_restart),
    .pwr_n(pwr_n)
  );

  assign abort = conv_restart | ~pwr_n;

  always_comb begin
    state_d = state_q;
    start   = 1'b0;
    if (abort) begin
      state_d = ST_RESET;
    end else begin
      unique case (state_q)
        ST_RESET:     state_d = ST_WAIT_HIGH;
        ST_WAIT_HIGH: if (line_s) state_d = ST_WAIT_LOW;
        ST_WAIT_LOW: begin
          if (!line_s) begin
            start   = 1'b1;
            state_d = ST_SHIFT;
          end
        end
        ST_SHIFT:     if (frame_done) state_d = ST_WAIT_HIGH;
        default:      state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  sdadc_sclk_gen #(
    .FRAME_BITS(FRAME_BITS),
    .LOW_CYC   (LOW_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .SAMPLE_DLY(SAMPLE_DLY)
  ) u_sclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .abort     (abort),
    .sclk      (ser_clk),
    .sample_stb(sample_stb),
    .frame_done(frame_done),
    .busy      (shifting)
  );

  sdadc_frame_check #(.HOLD_RESULT(HOLD_RESULT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (conv_restart),
    .sample_stb(sample_stb),
    .bit_in    (line_s),
    .frame_done(frame_done),
    .res_ready (res_ready),
    .res_valid (res_valid),
    .res_code  (res_code),
    .res_err   (res_err),
    .res_bad   (res_bad)
  );

  assign conv_pwr_n = pwr_n;

  assert_no_clock_in_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_pwr_n |-> ser_clk);

  assert_start_needs_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) == ST_WAIT_LOW && state_q == ST_SHIFT) |-> !$past(line_s));

  assert_shift_matches_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shifting |-> (state_q == ST_SHIFT));

endmodule

// File: tb/sdadc_host_reader_tb.sv
`timescale 1ns/1ps
module sdadc_host_reader_tb;

  localparam int LOW_CYC  = 16;
  localparam int HIGH_CYC = 13;
  localparam int RST_CYC  = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        conv_restart;
  logic        conv_pwr_n;
  logic        ser_clk;
  logic        ser_dat;
  logic        res_ready;
  logic        res_valid;
  logic [11:0] res_code;
  logic        res_err;
  logic        res_bad;

  int checks = 0;
  int failures = 0;

  always #4ns clk = ~clk;

  sdadc_host_reader u_dut (
    .clk(clk), .rst_n(rst_n), .conv_restart(conv_restart), .conv_pwr_n(conv_pwr_n),
    .ser_clk(ser_clk), .ser_dat(ser_dat), .res_ready(res_ready), .res_valid(res_valid),
    .res_code(res_code), .res_err(res_err), .res_bad(res_bad)
  );

  // converter model
  logic [23:0] frame_word;
  int          fall_idx;
  bit          model_active = 1'b0;
  bit          keep_low = 1'b0;

  always @(negedge ser_clk) begin : m_data
    int k;
    if (model_active && fall_idx < 24) begin
      k = fall_idx;
      fall_idx++;
      #40ns;
      if (model_active) ser_dat = frame_word[23-k];
    end
  end

  always @(posedge ser_clk) begin
    if (model_active && fall_idx == 24) begin
      ser_dat = keep_low ? 1'b0 : 1'b1;
      model_active = 1'b0;
    end
  end

  // clock shape monitor
  logic prev_clk_s = 1'b1;
  int   lowcnt = 0, highcnt = 0, falls = 0, width_bad = 0;

  always @(negedge clk) begin
    if (prev_clk_s && !ser_clk) begin
      falls++;
      if (falls > 1 && highcnt != HIGH_CYC) width_bad++;
      lowcnt = 1;
    end else if (!prev_clk_s && ser_clk) begin
      if (lowcnt != LOW_CYC) width_bad++;
      highcnt = 1;
    end else if (!ser_clk) lowcnt++;
    else highcnt++;
    prev_clk_s = ser_clk;
  end

  task automatic step();
    @(posedge clk);
    #2ns;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_bad(input logic [23:0] w);
    return (w[2:0] != 3'b101) || (w[11:8] != 4'h0) || w[6] || (w[4:3] != 2'b00);
  endfunction

  function automatic logic [23:0] make_word(input logic [11:0] code, input logic err,
                                            input int kind, input int r);
    logic [23:0] w;
    w = {code, 4'h0, 1'b0, 1'b0, err, 2'b00, 3'b101};
    case (kind)
      3: w[2:0] = w[2:0] ^ 3'((r % 7) + 1);
      4: w[8 + (r % 4)] = 1'b1;
      5: w[3 + (r % 2)] = 1'b1;
      6: w[6] = 1'b1;
      7: w[7] = 1'b1;
      default: ;
    endcase
    return w;
  endfunction

  task automatic consume();
    res_ready = 1'b1;
    step();
    res_ready = 1'b0;
    chk(!res_valid, "R8", "valid after accept", res_valid, 0);
  endtask

  task automatic run_frame(input logic [23:0] w, input bit kl, input bit hold_chk);
    int since;
    int n;
    logic [11:0] c0;
    ser_dat = 1'b1;
    repeat (6) step();
    falls = 0; width_bad = 0;
    frame_word = w; fall_idx = 0; keep_low = kl; model_active = 1'b1;
    ser_dat = 1'b0;
    since = -1; n = 0;
    while (!res_valid && n < 2000) begin
      step();
      n++;
      if (falls == 24 && ser_clk) since++;
    end
    chk(res_valid, "R5", "result delivered", res_valid, 1);
    chk(falls == 24, "R4", "falling edges per frame", falls, 24);
    chk(width_bad == 0, "R4", "phase widths off", width_bad, 0);
    chk(since == HIGH_CYC, "R5", "cycles from last rise to valid", since, HIGH_CYC);
    chk(res_code == w[23:12], "R5", "code", res_code, w[23:12]);
    chk(res_err == w[5], "R6", "err flag", res_err, w[5]);
    chk(res_bad == exp_bad(w), "R7", "integrity flag", res_bad, exp_bad(w));
    if (hold_chk) begin
      c0 = res_code;
      repeat (40) step();
      chk(res_valid && res_code == c0, "R8", "held result", res_code, c0);
    end
    consume();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n;
    int err_cnt;
    void'($urandom(32'd2024));
    rst_n = 1'b0; conv_restart = 1'b0; res_ready = 1'b0; ser_dat = 1'b0;
    repeat (3) step();
    // R1 reset state
    chk(ser_clk && !res_valid && !conv_pwr_n, "R1", "reset state clk/valid/pwr",
        {ser_clk, res_valid, conv_pwr_n}, 3'b100);
    rst_n = 1'b1;
    n = 0;
    while (!conv_pwr_n && n < 1000) begin step(); n++; end
    chk(n == RST_CYC, "R1", "power-up restart length", n, RST_CYC);

    // directed corners
    run_frame(make_word(12'h000, 1'b0, 0, 0), 1'b0, 1'b1);
    run_frame(make_word(12'hFFF, 1'b1, 0, 0), 1'b0, 1'b0);
    run_frame(make_word(12'h800, 1'b0, 3, 0), 1'b0, 1'b0);
    run_frame(make_word(12'h5A5, 1'b0, 4, 2), 1'b0, 1'b0);
    run_frame(make_word(12'hA5A, 1'b1, 5, 1), 1'b0, 1'b0);
    run_frame(make_word(12'h123, 1'b0, 6, 0), 1'b0, 1'b0);
    run_frame(make_word(12'h7FF, 1'b0, 7, 0), 1'b0, 1'b0); // R7 ready bit ignored

    // R3: line held low after a frame starts nothing
    run_frame(make_word(12'h3C3, 1'b0, 0, 0), 1'b1, 1'b0);
    falls = 0;
    repeat (300) step();
    chk(falls == 0 && !res_valid, "R3", "pulses with line stuck low", falls, 0);

    // R2: restart mid-frame with a pending result
    run_frame(make_word(12'h0F0, 1'b0, 0, 0), 1'b0, 1'b0);
    ser_dat = 1'b1; repeat (6) step();
    frame_word = make_word(12'h00F, 1'b0, 0, 0);
    res_ready = 1'b0;
    // make a pending result first
    falls = 0; fall_idx = 0; keep_low = 1'b0; model_active = 1'b1; ser_dat = 1'b0;
    n = 0;
    while (!res_valid && n < 2000) begin step(); n++; end
    ser_dat = 1'b1; repeat (6) step();
    falls = 0; fall_idx = 0; model_active = 1'b1; ser_dat = 1'b0;
    n = 0;
    while (falls < 5 && n < 2000) begin step(); n++; end
    conv_restart = 1'b1;
    step();
    conv_restart = 1'b0;
    model_active = 1'b0;
    ser_dat = 1'b0;
    chk(!res_valid, "R2", "pending result withdrawn", res_valid, 0);
    n = 0; err_cnt = 0;
    while (!conv_pwr_n && n < 1000) begin
      if (!ser_clk) err_cnt++;
      step(); n++;
    end
    chk(n == RST_CYC, "R2", "restart pulse length", n, RST_CYC);
    chk(err_cnt == 0, "R2", "clock low during restart", err_cnt, 0);
    falls = 0;
    repeat (300) step();
    chk(falls == 0 && !res_valid, "R3", "line low after restart ignored", falls, 0);

    // random frames
    for (int i = 0; i < 24; i++) begin
      logic [11:0] c;
      int kind;
      c = 12'($urandom);
      kind = int'($urandom % 8);
      run_frame(make_word(c, 1'($urandom), kind, int'($urandom % 16)), 1'b0, (i % 6) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule